// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns single requests from an on-chip master into timed cycles on an external memory bus. Each request carries a 24-bit address, a direction and write data. The controller sorts the address into one of four regions and pulls that region's active-low chip select. It then holds the read or write strobe low for as many clocks as the region's settings call for. One clock after the last bus state it returns an acknowledge pulse and, for reads, the data it captured.

Each region has its own settings: a fast two-clock access or a slow access of three clocks plus a programmable wait count, and for the general region a burst-ROM option. In burst-ROM mode, a read that follows a general-region read inside the same 16-byte line finishes in one or two clocks. A global setting adds one dead clock before a write whose previous bus cycle was a read. This gives the external data bus time to change direction.

Settings are written through a small configuration port. Indices 0 to 3 hold the region settings. Index 4 holds the global turnaround switch.

Top module: `xbus_seq`

## Requirements
- R1: After reset all chip selects, `rd_n`, `wr_n` and `ack` are inactive (selects and strobes high, `ack` low), and `ext_dout_en` is low.
- R2: Region decode picks exactly one chip select for each access. 0xF80000–0xFBFFFF drives `cs_n[1]`. 0xFFC000–0xFFDFFF drives `cs_n[2]`. 0xFFF000–0xFFF7FF drives `cs_n[3]`. Every other address drives `cs_n[0]`. A strobe is never low without a chip select.
- R3: With the region's slow bit (cfg bit 0) clear, the strobe stays low for exactly 2 clocks, whatever the wait field holds.
- R4: With the slow bit set, the strobe stays low for 3 + W clocks, where W is the wait field (cfg bits 4:3).
- R5: With burst enabled for region 0 (cfg bit 1), a read in region 0 whose address bits 23:4 match the previous bus cycle, which was also a region-0 read, lasts 1 clock (cfg bit 2 clear) or 2 clocks (bit 2 set). The first read of a line, and every write, use the full timing.
- R6: Burst settings written to regions 1–3 have no effect on their access length.
- R7: When the turnaround switch (index 4, bit 0) is set and the previous bus cycle was a read, a write begins with one clock in which the new address is on `ext_addr` while the selects and strobes are still high. A read after a write, and any cycle while the switch is clear, gets no such clock.
- R8: `ack` is high for exactly one clock, the clock after the last bus state. `rdata` then holds `ext_din` as it was in that last state.
- R9: A write holds `wr_n` low, `rd_n` high, `ext_dout_en` high and `ext_dout` equal to the request data for the whole access. A read holds `rd_n` low and `wr_n` high.
- R10: `ext_addr` stays constant while a chip select is low, and `rd_n` and `wr_n` are never both low.
- R11: Reset settings are: every region slow with a wait field of 3 (6-clock accesses), burst off, turnaround switch on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Request address |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Captured read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Setting index: 0–3 region, 4 global |
| cfg_wdata | input | 5 | {wait[1:0], burst_two, burst_en, slow}; bit 0 = turnaround at index 4 |
| ext_addr | output | 24 | External address |
| ext_dout | output | DATA_W | External write data |
| ext_dout_en | output | 1 | Data bus drive enable |
| ext_din | input | DATA_W | External read data |
| cs_n | output | 4 | Active-low region chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Two rules can apply to the same start decision: the turnaround clock and the burst shortening. Both depend on the type and place of the previous bus cycle. The bench provokes them by alternating reads and writes through every mode and wait setting, and by running region-0 burst chains that a write breaks. For each cycle, a monitor counts the clocks between the request and the first strobe, and the clocks the strobe stays low. It compares both counts with values that the driver predicts from its own copy of the settings and of the bus history.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int ADDR_W      = 24;
    localparam int NUM_REGIONS = 4;
    localparam int WAIT_W      = 2;
    localparam int LINE_BITS   = 4;
    localparam int CNT_W       = $clog2(3 + (1 << WAIT_W));
    localparam int CFG_IDX_W   = $clog2(NUM_REGIONS + 1);

    typedef enum logic [1:0] {
        RGN_GEN  = 2'd0,
        RGN_WIDE = 2'd1,
        RGN_CARD = 2'd2,
        RGN_IO   = 2'd3
    } region_e;

    // Packed so that slow sits in bit 0 of the configuration word
    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              burst_two;
        logic              burst_en;
        logic              slow;
    } rgn_cfg_t;

    localparam int CFG_W = $bits(rgn_cfg_t);

    localparam rgn_cfg_t CFG_RESET = '{waits: '1, burst_two: 1'b0,
                                       burst_en: 1'b0, slow: 1'b1};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TURN,
        ST_ACC
    } bus_st_e;

    function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
        region_e r;
        if (a[23:18] == 6'b111110)
            r = RGN_WIDE;
        else if (a[23:13] == 11'b11111111110)
            r = RGN_CARD;
        else if (a[23:11] == 13'b1111111111110)
            r = RGN_IO;
        else
            r = RGN_GEN;
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] access_len(input rgn_cfg_t c,
                                                    input logic follow);
        logic [CNT_W-1:0] n;
        if (follow)
            n = c.burst_two ? CNT_W'(2) : CNT_W'(1);
        else if (c.slow)
            n = CNT_W'(3) + CNT_W'(c.waits);
        else
            n = CNT_W'(2);
        return n;
    endfunction

endpackage

// File: rtl/xbus_cfg_bank.sv
module xbus_cfg_bank
    import xbus_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [CFG_IDX_W-1:0]                idx,
    input  logic [CFG_W-1:0]                    wdata,
    output rgn_cfg_t [NUM_REGIONS-1:0]          cfg,
    output logic                                idle_en
);

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
        always_ff @(posedge clk) begin
            if (rst)
                cfg[i] <= CFG_RESET;
            else if (we && idx == CFG_IDX_W'(i))
                cfg[i] <= rgn_cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            idle_en <= 1'b1;
        else if (we && idx == CFG_IDX_W'(NUM_REGIONS))
            idle_en <= wdata[0];
    end

endmodule

// File: rtl/xbus_region_dec.sv
module xbus_region_dec
    import xbus_pkg::*;
(
    input  logic [ADDR_W-1:0]      addr,
    output region_e                rgn,
    output logic [NUM_REGIONS-1:0] sel_n
);

    assign rgn = decode_region(addr);

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_sel
        assign sel_n[i] = (rgn != region_e'(i));
    end

endmodule

// File: rtl/xbus_burst_track.sv
module xbus_burst_track
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic              done_we,
    input  region_e           done_rgn,
    input  logic [ADDR_W-1:0] done_addr,
    input  logic              cand_we,
    input  region_e           cand_rgn,
    input  logic [ADDR_W-1:0] cand_addr,
    output logic              follow
);

    localparam int TAG_W = ADDR_W - LINE_BITS;

    logic [TAG_W-1:0] line_q;
    logic             valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= '0;
            valid_q <= 1'b0;
        end else if (done) begin
            line_q  <= done_addr[ADDR_W-1:LINE_BITS];
            valid_q <= !done_we && (done_rgn == RGN_GEN);
        end
    end

    assign follow = valid_q && !cand_we && (cand_rgn == RGN_GEN) &&
                    (cand_addr[ADDR_W-1:LINE_BITS] == line_q);

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic                   req_we,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  region_e                rgn,
    input  logic [NUM_REGIONS-1:0] sel_n,
    input  rgn_cfg_t               cfg_cur,
    input  logic                   idle_en,
    input  logic                   follow,
    input  logic [DATA_W-1:0]      ext_din,
    output logic                   ack,
    output logic [DATA_W-1:0]      rdata,
    output logic [ADDR_W-1:0]      ext_addr,
    output logic [DATA_W-1:0]      ext_dout,
    output logic                   ext_dout_en,
    output logic [NUM_REGIONS-1:0] cs_n,
    output logic                   rd_n,
    output logic                   wr_n,
    output logic                   done,
    output logic                   lat_we,
    output region_e                lat_rgn
);

    bus_st_e                st_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [NUM_REGIONS-1:0] pend_sel_q;
    logic                   prev_rd_q;
    logic                   start;
    logic                   need_turn;
    logic [CNT_W-1:0]       start_len;

    assign start     = (st_q == ST_IDLE) && req && !ack;
    assign need_turn = idle_en && req_we && prev_rd_q;
    assign start_len = access_len(cfg_cur, follow && cfg_cur.burst_en);
    assign done      = (st_q == ST_ACC) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            cnt_q       <= '0;
            pend_sel_q  <= '1;
            prev_rd_q   <= 1'b0;
            ack         <= 1'b0;
            rdata       <= '0;
            ext_addr    <= '0;
            ext_dout    <= '0;
            ext_dout_en <= 1'b0;
            cs_n        <= '1;
            rd_n        <= 1'b1;
            wr_n        <= 1'b1;
            lat_we      <= 1'b0;
            lat_rgn     <= RGN_GEN;
        end else begin
            ack <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        ext_addr   <= req_addr;
                        ext_dout   <= req_wdata;
                        lat_we     <= req_we;
                        lat_rgn    <= rgn;
                        pend_sel_q <= sel_n;
                        cnt_q      <= start_len - CNT_W'(1);
                        if (need_turn) begin
                            st_q <= ST_TURN;
                        end else begin
                            cs_n        <= sel_n;
                            rd_n        <= req_we;
                            wr_n        <= !req_we;
                            ext_dout_en <= req_we;
                            st_q        <= ST_ACC;
                        end
                    end
                end
                ST_TURN: begin
                    cs_n        <= pend_sel_q;
                    rd_n        <= lat_we;
                    wr_n        <= !lat_we;
                    ext_dout_en <= lat_we;
                    st_q        <= ST_ACC;
                end
                ST_ACC: begin
                    if (cnt_q == '0) begin
                        cs_n        <= '1;
                        rd_n        <= 1'b1;
                        wr_n        <= 1'b1;
                        ext_dout_en <= 1'b0;
                        ack         <= 1'b1;
                        prev_rd_q   <= !lat_we;
                        if (!lat_we)
                            rdata <= ext_din;
                        st_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic                   req_we,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   ack,
    output logic [DATA_W-1:0]      rdata,
    input  logic                   cfg_we,
    input  logic [CFG_IDX_W-1:0]   cfg_idx,
    input  logic [CFG_W-1:0]       cfg_wdata,
    output logic [ADDR_W-1:0]      ext_addr,
    output logic [DATA_W-1:0]      ext_dout,
    output logic                   ext_dout_en,
    input  logic [DATA_W-1:0]      ext_din,
    output logic [NUM_REGIONS-1:0] cs_n,
    output logic                   rd_n,
    output logic                   wr_n
);

    rgn_cfg_t [NUM_REGIONS-1:0] cfg_all;
    rgn_cfg_t                   cfg_cur;
    logic                       idle_en;
    region_e                    rgn;
    logic [NUM_REGIONS-1:0]     sel_n;
    logic                       follow;
    logic                       done;
    logic                       lat_we;
    region_e                    lat_rgn;

    xbus_cfg_bank u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .wdata   (cfg_wdata),
        .cfg     (cfg_all),
        .idle_en (idle_en)
    );

    xbus_region_dec u_dec (
        .addr  (req_addr),
        .rgn   (rgn),
        .sel_n (sel_n)
    );

    assign cfg_cur = cfg_all[rgn];

    xbus_burst_track u_burst (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .done_we   (lat_we),
        .done_rgn  (lat_rgn),
        .done_addr (ext_addr),
        .cand_we   (req_we),
        .cand_rgn  (rgn),
        .cand_addr (req_addr),
        .follow    (follow)
    );

    xbus_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rgn         (rgn),
        .sel_n       (sel_n),
        .cfg_cur     (cfg_cur),
        .idle_en     (idle_en),
        .follow      (follow),
        .ext_din     (ext_din),
        .ack         (ack),
        .rdata       (rdata),
        .ext_addr    (ext_addr),
        .ext_dout    (ext_dout),
        .ext_dout_en (ext_dout_en),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .done        (done),
        .lat_we      (lat_we),
        .lat_rgn     (lat_rgn)
    );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk
    import xbus_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   ack,
    input logic [ADDR_W-1:0]      ext_addr,
    input logic                   ext_dout_en,
    input logic [NUM_REGIONS-1:0] cs_n,
    input logic                   rd_n,
    input logic                   wr_n
);

    logic bus_on;
    assign bus_on = (cs_n != '1);

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R2
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> bus_on);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_on && $past(bus_on)) |-> $stable(ext_addr));

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R8
    ack_after_bus_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(bus_on));

    // R9
    drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        ext_dout_en |-> (!wr_n && rd_n));

endmodule

bind xbus_seq xbus_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack         (ack),
    .ext_addr    (ext_addr),
    .ext_dout_en (ext_dout_en),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n)
);

// File: tb/xbus_seq_test.sv
`timescale 1ns/1ps
module xbus_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [4:0]  cfg_wdata = '0;
    logic [23:0] ext_addr;
    logic [15:0] ext_dout;
    logic        ext_dout_en;
    logic [15:0] ext_din;
    logic [3:0]  cs_n;
    logic        rd_n;
    logic        wr_n;

    always #2.5 clk = ~clk;

    assign ext_din = ext_addr[15:0] ^ 16'hA55A;

    xbus_seq uut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .ext_addr(ext_addr),
        .ext_dout(ext_dout), .ext_dout_en(ext_dout_en), .ext_din(ext_din),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        int          len;
        int          pre;
        logic [3:0]  csn;
        logic        we;
        logic [23:0] addr;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Bench copy of the settings and of the bus history
    logic       sh_slow[4];
    int         sh_wait[4];
    logic       sh_ben[4];
    logic       sh_btwo[4];
    logic       sh_idle;
    logic       m_prev_rd;
    logic       m_bvalid;
    logic [19:0] m_bline;

    task automatic chk(input logic ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic int rgn_of(input logic [23:0] a);
        if (a >= 24'hF80000 && a <= 24'hFBFFFF) return 1;
        if (a >= 24'hFFC000 && a <= 24'hFFDFFF) return 2;
        if (a >= 24'hFFF000 && a <= 24'hFFF7FF) return 3;
        return 0;
    endfunction

    task automatic set_rgn(input int r, input logic slow, input logic ben,
                           input logic btwo, input int w);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = 3'(r);
        cfg_wdata = {2'(w), btwo, ben, slow};
        @(posedge clk); #1;
        cfg_we = 1'b0;
        sh_slow[r] = slow; sh_ben[r] = ben; sh_btwo[r] = btwo; sh_wait[r] = w;
    endtask

    task automatic set_idle(input logic en);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = 3'd4; cfg_wdata = {4'b0, en};
        @(posedge clk); #1;
        cfg_we = 1'b0;
        sh_idle = en;
    endtask

    task automatic txn(input logic we, input logic [23:0] addr,
                       input logic [15:0] wd, input string tag);
        exp_t e;
        int   r;
        logic fol;
        r   = rgn_of(addr);
        fol = m_bvalid && !we && r == 0 && sh_ben[0] && m_bline == addr[23:4];
        e.len  = fol ? (sh_btwo[0] ? 2 : 1) : (sh_slow[r] ? 3 + sh_wait[r] : 2);
        e.pre  = (sh_idle && we && m_prev_rd) ? 2 : 1;
        e.csn  = ~(4'b0001 << r);
        e.we   = we;
        e.addr = addr;
        e.data = we ? wd : (addr[15:0] ^ 16'hA55A);
        e.tag  = tag;
        exp_q.push_back(e);
        m_prev_rd = !we;
        m_bvalid  = (r == 0) && !we;
        m_bline   = addr[23:4];
        @(posedge clk); #1;
        req = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
        do begin
            @(posedge clk); #1;
        end while (!ack);
        req = 1'b0;
    endtask

    // Monitor: measures each cycle on the pins and compares with the queue
    initial begin
        int  pre_cnt = 0;
        int  acc_cnt = 0;
        bit  in_acc  = 0;
        forever begin
            @(negedge clk);
            if (rst) continue;
            if (cs_n != 4'hF) begin
                if (!in_acc) begin
                    in_acc  = 1;
                    acc_cnt = 0;
                    if (exp_q.size() > 0) begin
                        chk(cs_n == exp_q[0].csn, "R2", "chip select", cs_n, exp_q[0].csn);
                        chk(rd_n == exp_q[0].we && wr_n == !exp_q[0].we, "R9", "strobe kind",
                            {rd_n, wr_n}, {exp_q[0].we, !exp_q[0].we});
                        if (exp_q[0].we)
                            chk(ext_dout_en && ext_dout == exp_q[0].data, "R9", "write data",
                                {ext_dout_en, ext_dout}, {1'b1, exp_q[0].data});
                        chk(ext_addr == exp_q[0].addr, "R10", "address", ext_addr, exp_q[0].addr);
                    end
                end
                acc_cnt++;
            end else if (in_acc) begin
                in_acc = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected cycle", 0, 1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(acc_cnt == e.len, e.tag, "access clocks", acc_cnt, e.len);
                    chk(pre_cnt == e.pre, "R7", "clocks before strobe", pre_cnt, e.pre);
                    chk(ack == 1'b1, "R8", "ack after last state", ack, 1);
                    if (!e.we)
                        chk(rdata == e.data, "R8", "read data", rdata, e.data);
                end
                pre_cnt = 0;
            end else if (req && !ack) begin
                pre_cnt++;
                if (pre_cnt == 2 && exp_q.size() > 0)
                    chk(ext_addr == exp_q[0].addr, "R7", "address in idle clock",
                        ext_addr, exp_q[0].addr);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            sh_slow[i] = 1'b1; sh_wait[i] = 3; sh_ben[i] = 1'b0; sh_btwo[i] = 1'b0;
        end
        sh_idle = 1'b1; m_prev_rd = 1'b0; m_bvalid = 1'b0; m_bline = '0;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 4'hF && rd_n && wr_n, "R1", "strobes after reset",
            {cs_n, rd_n, wr_n}, 6'h3F);
        chk(!ack && !ext_dout_en, "R1", "ack/drive after reset",
            {ack, ext_dout_en}, 0);

        // R11: reset settings give a 6-clock access with turnaround on
        txn(1'b0, 24'h000100, 16'h0, "R11");
        txn(1'b1, 24'h000102, 16'h1234, "R11");

        // R3 / R4: every mode and wait count, write then read (R7 both ways)
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 4; w++) begin
                set_rgn(0, s[0], 1'b0, 1'b0, w);
                txn(1'b1, 24'h002000 + 24'(w * 64), 16'(16'hB000 + w), s ? "R4" : "R3");
                txn(1'b0, 24'h002000 + 24'(w * 64), 16'h0, s ? "R4" : "R3");
            end
        end

        // R2: region boundaries
        set_rgn(2, 1'b0, 1'b0, 1'b0, 3);
        txn(1'b0, 24'hF7FFFF, 16'h0, "R2");
        txn(1'b0, 24'hF80000, 16'h0, "R2");
        txn(1'b0, 24'hFBFFFF, 16'h0, "R2");
        txn(1'b0, 24'hFC0000, 16'h0, "R2");
        txn(1'b0, 24'hFFBFFF, 16'h0, "R2");
        txn(1'b1, 24'hFFC000, 16'h5A5A, "R2");
        txn(1'b0, 24'hFFDFFF, 16'h0, "R2");
        txn(1'b0, 24'hFFE000, 16'h0, "R2");
        txn(1'b0, 24'hFFF000, 16'h0, "R2");
        txn(1'b1, 24'hFFF7FF, 16'h0F0F, "R2");
        txn(1'b0, 24'hFFF800, 16'h0, "R2");

        // R5: burst chains in region 0, one-clock then two-clock follow-on
        set_rgn(0, 1'b1, 1'b1, 1'b0, 2);
        txn(1'b0, 24'h004000, 16'h0, "R5");
        txn(1'b0, 24'h004002, 16'h0, "R5");
        txn(1'b0, 24'h00400E, 16'h0, "R5");
        txn(1'b0, 24'h004010, 16'h0, "R5");
        txn(1'b1, 24'h004012, 16'h7777, "R5");
        txn(1'b0, 24'h004014, 16'h0, "R5");
        set_rgn(0, 1'b0, 1'b1, 1'b1, 0);
        txn(1'b0, 24'h004016, 16'h0, "R5");
        txn(1'b0, 24'h004018, 16'h0, "R5");

        // R6: burst bits in another region change nothing
        set_rgn(3, 1'b1, 1'b1, 1'b0, 1);
        txn(1'b0, 24'hFFF100, 16'h0, "R6");
        txn(1'b0, 24'hFFF102, 16'h0, "R6");
        set_rgn(1, 1'b0, 1'b1, 1'b1, 3);
        txn(1'b0, 24'hF80020, 16'h0, "R6");
        txn(1'b0, 24'hF80022, 16'h0, "R6");

        // R7: turnaround switched off
        set_idle(1'b0);
        txn(1'b0, 24'h006000, 16'h0, "R7");
        txn(1'b1, 24'h006002, 16'hCAFE, "R7");
        set_idle(1'b1);
        txn(1'b0, 24'h006004, 16'h0, "R7");
        txn(1'b1, 24'h006006, 16'hBEEF, "R7");

        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "R8", "cycles left unseen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule